// File: doc/BRIEF.md
# B/D Channel Frame Packer

This block sits between the bit-level framing of one digital subscriber port and a host that services it at a fixed rate. The port carries two 64 kb/s bearer channels (B1, B2) and one 16 kb/s signalling channel (D), 144 kb/s in all. On each strobe for a channel the block takes one received bit and, in the same cycle, presents the next bit to send. Over a buffer period of several frames it gathers the received bits into one wide register per channel and spreads the host-supplied transmit words over the same frames.

At each period boundary the received words move into host-readable shadow registers, and the transmit shadow words move into the transmit shift registers, both on the same clock edge. A single interrupt is raised for both directions at that boundary. The host then reads the receive data and refills the transmit data in one service routine. If the host misses a refill, the old transmit words are sent again and an underrun flag records this. With the default 8 kHz frames and four frames per period, the interrupt rate is 2 kHz.

Top module: `bd_frame_packer`

## Requirements
- R1: After reset, every receive shadow output is all ones, `irq` and `tx_underrun` are 0, and the transmit shift registers hold all ones, so every transmitted bit before the first boundary is 1.
- R2: Receive bits are packed MSB first, and the earliest frame occupies the most significant end. Each frame carries 8 B1 bits, 8 B2 bits and 2 D bits, so one period yields 32-bit B words and an 8-bit D word. A strobe shifts only its own channel.
- R3: The first `fsync` after reset only starts frame counting. From then on, every fourth `fsync` is a period boundary. The receive words become visible on `rx_*_q` one clock after the boundary edge, and the outputs do not change at any other time.
- R4: At a boundary, the transmit shadow words load into the shift registers. While a channel strobe is high, `tx_bit` shows that channel's next bit, MSB first, and the register advances at the edge. With no strobe high, `tx_bit` is 1.
- R5: `irq` goes to 1 one clock after each boundary and stays at 1 until `irq_clr` is asserted. If a boundary and `irq_clr` occur in the same cycle, `irq` stays set.
- R6: If `tx_wr` was not asserted since the previous boundary, the next boundary reloads the previous shadow words, so the same data is sent again. It also sets `tx_underrun`, which stays at 1 until `irq_clr` is asserted.
- R7: A `tx_wr` in the boundary cycle writes the shadow for the following period. The shift registers receive the older shadow contents, and that write counts as the refill for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame boundary pulse, one cycle |
| b1_stb | input | 1 | B1 bit slot strobe |
| b2_stb | input | 1 | B2 bit slot strobe |
| d_stb | input | 1 | D bit slot strobe |
| rx_bit | input | 1 | Serial receive data, sampled on a strobe |
| tx_bit | output | 1 | Serial transmit data for the strobed slot |
| tx_wr | input | 1 | Write transmit shadow registers |
| tx_b1_wdata | input | 32 | B1 transmit word for the next period |
| tx_b2_wdata | input | 32 | B2 transmit word for the next period |
| tx_d_wdata | input | 8 | D transmit word for the next period |
| rx_b1_q | output | 32 | Last completed B1 receive word |
| rx_b2_q | output | 32 | Last completed B2 receive word |
| rx_d_q | output | 8 | Last completed D receive word |
| irq | output | 1 | Common service interrupt, pending until cleared |
| irq_clr | input | 1 | Clears `irq` and `tx_underrun` |
| tx_underrun | output | 1 | Sticky flag: a period began without a refill |

## Verification
The hardest case to reach from the ports is a host write that falls in the same cycle as a boundary. In that case the shift registers must take the older shadow contents, while the new write still counts as the refill for the next period. The stimulus drives `tx_wr` and `irq_clr` together with the boundary `fsync`, after a period that was itself refilled. It then observes two later periods on `tx_bit`: the first must carry the earlier write, and the second must carry the coincident write without an underrun. A preceding run of missed refills holds `irq` and `tx_underrun` set across a whole period, so their stickiness and the priority of set over clear are both visible.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
   localparam int NUM_LANES = 3;
   localparam int LANE_D    = 2;

   function automatic int lane_width(input int idx, input int wb, input int wd);
      return (idx == LANE_D) ? wd : wb;
   endfunction

   function automatic int lane_offset(input int idx, input int wb);
      return idx * wb;
   endfunction
endpackage

// File: rtl/bdp_period_ctl.sv
module bdp_period_ctl #(
   parameter int FRAMES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsync,
   input  logic tx_wr,
   input  logic irq_clr,
   output logic xfer,
   output logic irq,
   output logic underrun
);
   localparam int CW = (FRAMES > 2) ? $clog2(FRAMES) : 1;

   logic          running;
   logic [CW-1:0] frm_cnt;
   logic          tx_fresh;
   logic          last_frm;

   assign last_frm = (frm_cnt == CW'(FRAMES - 1));
   assign xfer     = fsync & running & last_frm;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running  <= 1'b0;
         frm_cnt  <= '0;
         tx_fresh <= 1'b0;
         irq      <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (fsync) begin
            if (!running) begin
               running <= 1'b1;
               frm_cnt <= '0;
            end else if (last_frm) begin
               frm_cnt <= '0;
            end else begin
               frm_cnt <= frm_cnt + CW'(1);
            end
         end
         if (tx_wr)     tx_fresh <= 1'b1;
         else if (xfer) tx_fresh <= 1'b0;
         if (xfer)         irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
         if (xfer && !tx_fresh) underrun <= 1'b1;
         else if (irq_clr)      underrun <= 1'b0;
      end
   end
endmodule

// File: rtl/bdp_rx_lane.sv
module bdp_rx_lane #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic         din,
   input  logic         xfer,
   output logic [W-1:0] q
);
   logic [W-1:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh <= '1;
         q  <= '1;
      end else if (xfer) begin
         q  <= sh;
         sh <= '1;
      end else if (stb) begin
         sh <= {sh[W-2:0], din};
      end
   end
endmodule

// File: rtl/bdp_tx_lane.sv
module bdp_tx_lane #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic         xfer,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic         msb
);
   logic [W-1:0] shadow;
   logic [W-1:0] sh;

   assign msb = sh[W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '1;
         sh     <= '1;
      end else begin
         if (wr) shadow <= wdata;
         if (xfer)     sh <= shadow;
         else if (stb) sh <= {sh[W-2:0], 1'b1};
      end
   end
endmodule

// File: rtl/bd_frame_packer.sv
module bd_frame_packer #(
   parameter int BITS_B = 8,
   parameter int BITS_D = 2,
   parameter int FRAMES = 4,
   localparam int W_B   = BITS_B * FRAMES,
   localparam int W_D   = BITS_D * FRAMES
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fsync,
   input  logic           b1_stb,
   input  logic           b2_stb,
   input  logic           d_stb,
   input  logic           rx_bit,
   output logic           tx_bit,
   input  logic           tx_wr,
   input  logic [W_B-1:0] tx_b1_wdata,
   input  logic [W_B-1:0] tx_b2_wdata,
   input  logic [W_D-1:0] tx_d_wdata,
   output logic [W_B-1:0] rx_b1_q,
   output logic [W_B-1:0] rx_b2_q,
   output logic [W_D-1:0] rx_d_q,
   output logic           irq,
   input  logic           irq_clr,
   output logic           tx_underrun
);
   import bdp_pkg::*;

   localparam int TOT = 2 * W_B + W_D;

   if (BITS_B < 1 || BITS_D < 1) begin : g_bad_bits
      $error("bd_frame_packer: channel bit counts must be at least 1");
   end
   if (FRAMES < 2) begin : g_bad_frames
      $error("bd_frame_packer: FRAMES must be at least 2");
   end
   if (W_D < 2) begin : g_bad_dwidth
      $error("bd_frame_packer: D word must be at least 2 bits");
   end

   logic                 xfer;
   logic [NUM_LANES-1:0] stb_v;
   logic [NUM_LANES-1:0] msb_v;
   logic [TOT-1:0]       wdata_all;
   logic [TOT-1:0]       rdata_all;

   assign stb_v     = {d_stb, b2_stb, b1_stb};
   assign wdata_all = {tx_d_wdata, tx_b2_wdata, tx_b1_wdata};
   assign rx_b1_q   = rdata_all[0 +: W_B];
   assign rx_b2_q   = rdata_all[W_B +: W_B];
   assign rx_d_q    = rdata_all[2*W_B +: W_D];
   assign tx_bit    = (stb_v == '0) ? 1'b1 : |(stb_v & msb_v);

   bdp_period_ctl #(.FRAMES(FRAMES)) ctl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync    (fsync),
      .tx_wr    (tx_wr),
      .irq_clr  (irq_clr),
      .xfer     (xfer),
      .irq      (irq),
      .underrun (tx_underrun)
   );

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int LW = lane_width(i, W_B, W_D);
      localparam int LO = lane_offset(i, W_B);

      bdp_rx_lane #(.W(LW)) rx_i (
         .clk   (clk),
         .rst_n (rst_n),
         .stb   (stb_v[i]),
         .din   (rx_bit),
         .xfer  (xfer),
         .q     (rdata_all[LO +: LW])
      );

      bdp_tx_lane #(.W(LW)) tx_i (
         .clk   (clk),
         .rst_n (rst_n),
         .stb   (stb_v[i]),
         .xfer  (xfer),
         .wr    (tx_wr),
         .wdata (wdata_all[LO +: LW]),
         .msb   (msb_v[i])
      );
   end
endmodule

// File: rtl/bd_frame_packer_chk.sv
module bd_frame_packer_chk #(
   parameter int W_B = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           fsync,
   input logic           irq,
   input logic           irq_clr,
   input logic           tx_underrun,
   input logic [W_B-1:0] rx_b1_q
);
   // R5
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   // R5
   irq_after_fsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(fsync));

   // R3
   rx_update_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_b1_q) |-> $past(fsync));

   // R6
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_underrun && !irq_clr) |=> tx_underrun);

   // R6
   underrun_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_underrun) |-> $past(fsync));

   // R6
   underrun_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_underrun) |-> irq);
endmodule

bind bd_frame_packer bd_frame_packer_chk #(.W_B(W_B)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .fsync       (fsync),
   .irq         (irq),
   .irq_clr     (irq_clr),
   .tx_underrun (tx_underrun),
   .rx_b1_q     (rx_b1_q)
);

// File: tb/bd_frame_packer_tb_top.sv
module bd_frame_packer_tb_top;
   typedef struct packed {
      logic [31:0] rb1;
      logic [31:0] rb2;
      logic [7:0]  rd;
      logic [31:0] tb1;
      logic [31:0] tb2;
      logic [7:0]  td;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{32'h12345678, 32'h9ABCDEF0, 8'hA5, 32'h0F1E2D3C, 32'h4B5A6978, 8'h3C},
      '{32'h00000000, 32'hFFFFFFFF, 8'h00, 32'hFFFFFFFF, 32'h00000000, 8'hFF},
      '{32'hAAAA5555, 32'h5555AAAA, 8'h96, 32'h80000001, 32'h7FFFFFFE, 8'h81},
      '{32'hDEADBEEF, 32'h01234567, 8'h5A, 32'hC3C3C3C3, 32'h3C3C3C3C, 8'h69}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, fsync, b1_stb, b2_stb, d_stb, rx_bit, tx_bit;
   logic        tx_wr, irq, irq_clr, tx_underrun;
   logic [31:0] tx_b1_wdata, tx_b2_wdata, rx_b1_q, rx_b2_q;
   logic [7:0]  tx_d_wdata, rx_d_q;

   logic [31:0] cur_rb1, cur_rb2, cap_b1, cap_b2;
   logic [7:0]  cur_rd, cap_d;
   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   bd_frame_packer dut_i (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .b1_stb(b1_stb), .b2_stb(b2_stb),
      .d_stb(d_stb), .rx_bit(rx_bit), .tx_bit(tx_bit), .tx_wr(tx_wr),
      .tx_b1_wdata(tx_b1_wdata), .tx_b2_wdata(tx_b2_wdata), .tx_d_wdata(tx_d_wdata),
      .rx_b1_q(rx_b1_q), .rx_b2_q(rx_b2_q), .rx_d_q(rx_d_q), .irq(irq),
      .irq_clr(irq_clr), .tx_underrun(tx_underrun)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put_bit(input int lane, input logic v, output logic t);
      case (lane)
         0:       b1_stb = 1'b1;
         1:       b2_stb = 1'b1;
         default: d_stb  = 1'b1;
      endcase
      rx_bit = v;
      #1 t = tx_bit;
      @(negedge clk);
      b1_stb = 1'b0; b2_stb = 1'b0; d_stb = 1'b0; rx_bit = 1'b0;
   endtask

   task automatic send_frame(input int f);
      logic t;
      for (int j = 0; j < 8; j++) begin
         put_bit(0, cur_rb1[31-(f*8+j)], t); cap_b1[31-(f*8+j)] = t;
      end
      for (int j = 0; j < 8; j++) begin
         put_bit(1, cur_rb2[31-(f*8+j)], t); cap_b2[31-(f*8+j)] = t;
      end
      for (int j = 0; j < 2; j++) begin
         put_bit(2, cur_rd[7-(f*2+j)], t); cap_d[7-(f*2+j)] = t;
      end
   endtask

   task automatic pulse_fsync(input logic clr, input logic wr,
                              input logic [31:0] w1, input logic [31:0] w2, input logic [7:0] wd);
      fsync = 1'b1; irq_clr = clr; tx_wr = wr;
      tx_b1_wdata = w1; tx_b2_wdata = w2; tx_d_wdata = wd;
      @(negedge clk);
      fsync = 1'b0; irq_clr = 1'b0; tx_wr = 1'b0;
   endtask

   task automatic host_write(input logic [31:0] w1, input logic [31:0] w2, input logic [7:0] wd);
      tx_wr = 1'b1; tx_b1_wdata = w1; tx_b2_wdata = w2; tx_d_wdata = wd;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic clear_irq();
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   // Frames 0..3 of a period; the closing boundary fsync is left to the caller.
   task automatic run_frames();
      for (int f = 0; f < 3; f++) begin
         send_frame(f);
         pulse_fsync(1'b0, 1'b0, '0, '0, '0);
      end
      send_frame(3);
   endtask

   task automatic chk_rx(input string tag);
      chk({tag, " rx_b1"}, rx_b1_q, cur_rb1);
      chk({tag, " rx_b2"}, rx_b2_q, cur_rb2);
      chk({tag, " rx_d"}, {24'h0, rx_d_q}, {24'h0, cur_rd});
   endtask

   task automatic chk_tx(input string tag, input logic [31:0] e1, input logic [31:0] e2, input logic [7:0] ed);
      chk({tag, " tx_b1"}, cap_b1, e1);
      chk({tag, " tx_b2"}, cap_b2, e2);
      chk({tag, " tx_d"}, {24'h0, cap_d}, {24'h0, ed});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; fsync = 1'b0; b1_stb = 1'b0; b2_stb = 1'b0; d_stb = 1'b0;
      rx_bit = 1'b0; tx_wr = 1'b0; irq_clr = 1'b0;
      tx_b1_wdata = '0; tx_b2_wdata = '0; tx_d_wdata = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rx_b1 reset", rx_b1_q, 32'hFFFFFFFF);
      chk("R1 rx_b2 reset", rx_b2_q, 32'hFFFFFFFF);
      chk("R1 rx_d reset", {24'h0, rx_d_q}, 32'hFF);
      chk("R1 irq reset", {31'h0, irq}, 32'h0);
      chk("R1 underrun reset", {31'h0, tx_underrun}, 32'h0);
      chk("R1 tx idle", {31'h0, tx_bit}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 first fsync only starts counting
      pulse_fsync(1'b0, 1'b0, '0, '0, '0);
      chk("R3 no irq on first fsync", {31'h0, irq}, 32'h0);

      for (int i = 0; i < 4; i++) begin
         host_write(VECS[i].tb1, VECS[i].tb2, VECS[i].td);
         cur_rb1 = VECS[i].rb1; cur_rb2 = VECS[i].rb2; cur_rd = VECS[i].rd;
         run_frames();
         chk("R3 no early boundary", {31'h0, irq}, 32'h0);
         pulse_fsync(1'b0, 1'b0, '0, '0, '0);
         chk_rx("R2");
         chk("R5 irq set", {31'h0, irq}, 32'h1);
         chk("R6 no underrun", {31'h0, tx_underrun}, 32'h0);
         if (i == 0) chk_tx("R1 tx ones", 32'hFFFFFFFF, 32'hFFFFFFFF, 8'hFF);
         else        chk_tx("R4", VECS[i-1].tb1, VECS[i-1].tb2, VECS[i-1].td);
         clear_irq();
         chk("R5 irq cleared", {31'h0, irq}, 32'h0);
      end

      // Period A: no refill
      cur_rb1 = ~VECS[0].rb1; cur_rb2 = ~VECS[0].rb2; cur_rd = ~VECS[0].rd;
      run_frames();
      pulse_fsync(1'b0, 1'b0, '0, '0, '0);
      chk_rx("R2 A");
      chk_tx("R4 A", VECS[3].tb1, VECS[3].tb2, VECS[3].td);
      chk("R6 underrun set", {31'h0, tx_underrun}, 32'h1);

      // Period B: refill Q, irq left pending; boundary with clear and write P together
      host_write(32'h11223344, 32'h55667788, 8'h99);
      cur_rb1 = ~VECS[2].rb1; cur_rb2 = VECS[3].rb2; cur_rd = 8'h3C;
      run_frames();
      chk("R5 irq held", {31'h0, irq}, 32'h1);
      chk("R6 underrun sticky", {31'h0, tx_underrun}, 32'h1);
      pulse_fsync(1'b1, 1'b1, 32'hCAFEF00D, 32'hBADC0FFE, 8'hE7);
      chk_rx("R2 B");
      chk_tx("R6 resend", VECS[3].tb1, VECS[3].tb2, VECS[3].td);
      chk("R5 set wins over clear", {31'h0, irq}, 32'h1);
      chk("R6 underrun cleared", {31'h0, tx_underrun}, 32'h0);

      // Period C: no write; boundary write P counts as refill
      clear_irq();
      cur_rb1 = 32'h0000FFFF; cur_rb2 = 32'hF0F0F0F0; cur_rd = 8'hC3;
      run_frames();
      pulse_fsync(1'b0, 1'b0, '0, '0, '0);
      chk_rx("R2 C");
      chk_tx("R7 older shadow", 32'h11223344, 32'h55667788, 8'h99);
      chk("R7 no underrun", {31'h0, tx_underrun}, 32'h0);

      // Period D: P is transmitted; no refill since
      clear_irq();
      run_frames();
      pulse_fsync(1'b0, 1'b0, '0, '0, '0);
      chk_tx("R7 coincident write", 32'hCAFEF00D, 32'hBADC0FFE, 8'hE7);
      chk("R6 underrun again", {31'h0, tx_underrun}, 32'h1);
      chk("R4 tx idle", {31'h0, tx_bit}, 32'h1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule